// File: doc/BRIEF.md
# Paired Add/Subtract SIMD Arithmetic Unit

This unit takes one operation code and two 32-bit operands, and registers a 64-bit result one clock later. The main operation type forms the sum and the difference of the same operand pair in parallel. The upper result word holds the sum and the lower word holds the difference. The pair can be computed as one 32-bit quantity or as two separate 16-bit lanes, and each form has a wrapping variant and a signed saturating variant.

The same datapath also has a group of lane-wise helpers used around packed 16-bit arithmetic:
- a signed per-lane maximum and minimum of two halfword pairs;
- widening of a byte pair to halfwords, signed or unsigned, from either the low or the high half of each operand;
- narrowing of four signed halfwords to four bytes, with an unsigned or a signed clamp.

The unit issues no instructions and writes back to no register file. Whatever drives it presents an operation with `in_valid` high and collects `res` when `res_valid` is high on the following cycle.

Top module: `simd_addsub_alu`

## Requirements
- R1: A result appears exactly one cycle after its operands, with `res_valid` high, when `in_valid` is high and the operation code is in the range 0..10. If `in_valid` is low, or the code is one of 11..15, then `res_valid` is low and `res` is all zeros on the next cycle.
- R2: Code 0 (wrapping 32-bit pair): `res[63:32]` = A+B mod 2^32 and `res[31:0]` = A-B mod 2^32.
- R3: Code 1 (saturating 32-bit pair): the signed sum and the signed difference are each clamped to the range 0x80000000..0x7FFFFFFF. The layout is the same as in R2.
- R4: Code 2 (wrapping dual 16-bit pair): lane 0 is bits 15:0 and lane 1 is bits 31:16 of each operand and of each result word. The sum lanes go in `res[63:32]` and the difference lanes go in `res[31:0]`. No carry and no borrow pass from lane 0 into lane 1.
- R5: Code 3 (saturating dual 16-bit pair): the layout is the same as in R4. Each lane's signed sum and difference are clamped to the range 0x8000..0x7FFF.
- R6: Code 4 (dual min/max): each lane of `res[63:32]` is the signed maximum of the A and B lanes. Each lane of `res[31:0]` is the signed minimum of those lanes.
- R7: Codes 5..8 widen bytes into halfwords. `res[63:32]` comes from A and `res[31:0]` comes from B.
  - Code 5 takes bytes 1:0 of the operand and zero-extends them.
  - Code 6 takes bytes 1:0 and sign-extends them.
  - Code 7 takes bytes 3:2 and zero-extends them.
  - Code 8 takes bytes 3:2 and sign-extends them.
  - In every case, the lower source byte fills the lower halfword.
- R8: Code 9 (unsigned narrowing): each signed halfword is clamped to 0..255. Byte 3 of `res[31:0]` comes from A[31:16], byte 2 from A[15:0], byte 1 from B[31:16] and byte 0 from B[15:0]. `res[63:32]` is zero.
- R9: Code 10 (signed narrowing): the byte layout is the same as in R8. Each signed halfword is clamped to -128..127, that is 0x80..0x7F.
- R10: While reset is asserted, and on the first cycle after it is released, `res_valid` is low and `res` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and operation code are present this cycle |
| opcode | input | 4 | Operation select, codes 0..10 |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| res | output | 64 | Upper word: sum, max or A-derived half. Lower word: difference, min or packed bytes |
| res_valid | output | 1 | `res` holds the result of the operation issued one cycle earlier |

## Verification
On every cycle, the assertions check the one-cycle relation between `in_valid` and `res_valid`. They also check a set of consistency properties that hold without knowing the exact expected value:
- in the wrapping 32-bit pair, sum plus difference equals twice A;
- a saturated sum never takes a sign opposite to that of two like-signed operands, in both the 32-bit form and each 16-bit lane;
- each maximum lane is never below its minimum lane.

The exact result values can only be shown by the bench's sweeps over edge operands and random words. These values include:
- the clamp constants;
- the absence of a carry between lanes;
- the byte ordering of widening and narrowing;
- the zero result for idle and reserved codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_AS32   = 4'd0,
        OP_AS32S  = 4'd1,
        OP_AS2    = 4'd2,
        OP_AS2S   = 4'd3,
        OP_MM2    = 4'd4,
        OP_UNPLU  = 4'd5,
        OP_UNPLS  = 4'd6,
        OP_UNPHU  = 4'd7,
        OP_UNPHS  = 4'd8,
        OP_PKU    = 4'd9,
        OP_PKS    = 4'd10
    } alu_op_e;

    localparam logic [OPW-1:0] OP_LAST = OP_PKS;

endpackage

// File: rtl/addsub_lane.sv
module addsub_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sat,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff
);
    logic [W-1:0] sum_raw;
    logic [W-1:0] diff_raw;
    logic [W-1:0] clamp_v;
    logic         ovf_sum;
    logic         ovf_diff;

    always_comb begin
        sum_raw  = a + b;
        diff_raw = a - b;
        // Signed overflow: result sign disagrees with what the operand signs allow
        ovf_sum  = (a[W-1] == b[W-1]) && (sum_raw[W-1]  != a[W-1]);
        ovf_diff = (a[W-1] != b[W-1]) && (diff_raw[W-1] != a[W-1]);
        // On overflow the true result has the sign of a: negative -> most negative
        clamp_v  = {a[W-1], {(W-1){~a[W-1]}}};
        sum      = (sat && ovf_sum)  ? clamp_v : sum_raw;
        diff     = (sat && ovf_diff) ? clamp_v : diff_raw;
    end
endmodule

// File: rtl/minmax_lane.sv
module minmax_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mx,
    output logic [W-1:0] mn
);
    logic a_gt_b;

    always_comb begin
        a_gt_b = $signed(a) > $signed(b);
        mx     = a_gt_b ? a : b;
        mn     = a_gt_b ? b : a;
    end
endmodule

// File: rtl/unpack_unit.sv
module unpack_unit #(
    parameter int DW = 32,
    parameter int HW = 16,
    parameter int BW = 8
) (
    input  logic [DW-1:0] w,
    input  logic          hi_sel,
    input  logic          sgn,
    output logic [DW-1:0] out
);
    localparam int LANES = DW / HW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BW-1:0] src;
        always_comb begin
            src = hi_sel ? w[(LANES + g)*BW +: BW] : w[g*BW +: BW];
            out[g*HW +: HW] = {{(HW-BW){sgn & src[BW-1]}}, src};
        end
    end
endmodule

// File: rtl/pack_unit.sv
module pack_unit #(
    parameter int DW = 32,
    parameter int HW = 16,
    parameter int BW = 8
) (
    input  logic [DW-1:0]                 a,
    input  logic [DW-1:0]                 b,
    input  logic                          sgn,
    output logic [(2*DW/HW)*BW-1:0]       out
);
    localparam int NH = 2 * DW / HW;

    logic [2*DW-1:0] ab;
    assign ab = {a, b};

    for (genvar g = 0; g < NH; g++) begin : g_half
        logic [HW-1:0] h;
        logic          fits_s;
        logic          fits_u;
        always_comb begin
            h      = ab[g*HW +: HW];
            // signed byte range: bits HW-1 .. BW-1 all equal
            fits_s = (&h[HW-1:BW-1]) | ~(|h[HW-1:BW-1]);
            // unsigned byte range: sign clear and no bits above BW-1
            fits_u = ~(|h[HW-1:BW]);
            if (sgn) begin
                out[g*BW +: BW] = fits_s ? h[BW-1:0] : {h[HW-1], {(BW-1){~h[HW-1]}}};
            end else if (h[HW-1]) begin
                out[g*BW +: BW] = '0;
            end else begin
                out[g*BW +: BW] = fits_u ? h[BW-1:0] : '1;
            end
        end
    end
endmodule

// File: rtl/simd_addsub_alu.sv
module simd_addsub_alu
    import alu_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16,
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OPW-1:0]  opcode,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic [2*DW-1:0] res,
    output logic            res_valid
);
    localparam int LANES = DW / HW;
    localparam int RW    = 2 * DW;
    localparam int PW    = (2 * DW / HW) * BW;

    typedef struct packed {
        logic          vld;
        logic [RW-1:0] res;
    } alu_reg_t;

    alu_reg_t st_d, st_q;

    // ---------------- datapath pieces ----------------
    logic [DW-1:0] sum_w, diff_w;
    logic [DW-1:0] sum_l, diff_l;
    logic [DW-1:0] max_l, min_l;
    logic [DW-1:0] unp_a, unp_b;
    logic [PW-1:0] pk;
    logic          unp_hi, unp_sgn;

    addsub_lane #(.W(DW)) u_word (
        .a    (opa),
        .b    (opb),
        .sat  (opcode == OP_AS32S),
        .sum  (sum_w),
        .diff (diff_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        addsub_lane #(.W(HW)) u_as (
            .a    (opa[g*HW +: HW]),
            .b    (opb[g*HW +: HW]),
            .sat  (opcode == OP_AS2S),
            .sum  (sum_l[g*HW +: HW]),
            .diff (diff_l[g*HW +: HW])
        );
        minmax_lane #(.W(HW)) u_mm (
            .a  (opa[g*HW +: HW]),
            .b  (opb[g*HW +: HW]),
            .mx (max_l[g*HW +: HW]),
            .mn (min_l[g*HW +: HW])
        );
    end

    assign unp_hi  = (opcode == OP_UNPHU) || (opcode == OP_UNPHS);
    assign unp_sgn = (opcode == OP_UNPLS) || (opcode == OP_UNPHS);

    unpack_unit #(.DW(DW), .HW(HW), .BW(BW)) u_unp_a (
        .w (opa), .hi_sel (unp_hi), .sgn (unp_sgn), .out (unp_a)
    );
    unpack_unit #(.DW(DW), .HW(HW), .BW(BW)) u_unp_b (
        .w (opb), .hi_sel (unp_hi), .sgn (unp_sgn), .out (unp_b)
    );

    pack_unit #(.DW(DW), .HW(HW), .BW(BW)) u_pack (
        .a (opa), .b (opb), .sgn (opcode == OP_PKS), .out (pk)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.vld = 1'b1;
            case (opcode)
                OP_AS32, OP_AS32S:   st_d.res = {sum_w, diff_w};
                OP_AS2, OP_AS2S:     st_d.res = {sum_l, diff_l};
                OP_MM2:              st_d.res = {max_l, min_l};
                OP_UNPLU, OP_UNPLS,
                OP_UNPHU, OP_UNPHS:  st_d.res = {unp_a, unp_b};
                OP_PKU, OP_PKS:      st_d.res = {{(RW-PW){1'b0}}, pk};
                default:             st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res       = st_q.res;
    assign res_valid = st_q.vld;

    // ---------------- assertions ----------------
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(in_valid && (opcode <= OP_LAST))));

    a_r2_sum_plus_diff: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && (opcode == OP_AS32)))
        |-> ((res[RW-1:DW] + res[DW-1:0]) == ($past(opa) << 1)));

    a_r3_sat_word_sign: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && (opcode == OP_AS32S))
         && ($past(opa[DW-1]) == $past(opb[DW-1])))
        |-> (res[RW-1] == $past(opa[DW-1])));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        a_r5_sat_lane_sign: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid && (opcode == OP_AS2S))
             && ($past(opa[g*HW+HW-1]) == $past(opb[g*HW+HW-1])))
            |-> (res[DW+g*HW+HW-1] == $past(opa[g*HW+HW-1])));

        a_r6_max_ge_min: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid && (opcode == OP_MM2)))
            |-> ($signed(res[DW+g*HW +: HW]) >= $signed(res[g*HW +: HW])));
    end

endmodule

// File: tb/sim_simd_addsub_alu.sv
module sim_simd_addsub_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [63:0] res;
    logic        res_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    simd_addsub_alu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .opa       (opa),
        .opb       (opb),
        .res       (res),
        .res_valid (res_valid)
    );

    function automatic longint clamp(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [64:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] r;
        logic [63:0] ab;
        longint x, y, s, d;
        int base;
        bit sg;
        r = '0;
        ab = {a, b};
        case (op)
            4'd0: r = {a + b, a - b};
            4'd1: begin
                x = longint'($signed(a));
                y = longint'($signed(b));
                r[63:32] = 32'(clamp(x + y, -64'sd2147483648, 64'sd2147483647));
                r[31:0]  = 32'(clamp(x - y, -64'sd2147483648, 64'sd2147483647));
            end
            4'd2, 4'd3: for (int l = 0; l < 2; l++) begin
                x = longint'($signed(a[l*16 +: 16]));
                y = longint'($signed(b[l*16 +: 16]));
                s = x + y;
                d = x - y;
                if (op == 4'd3) begin
                    s = clamp(s, -32768, 32767);
                    d = clamp(d, -32768, 32767);
                end
                r[32 + l*16 +: 16] = 16'(s);
                r[l*16 +: 16]      = 16'(d);
            end
            4'd4: for (int l = 0; l < 2; l++) begin
                x = longint'($signed(a[l*16 +: 16]));
                y = longint'($signed(b[l*16 +: 16]));
                r[32 + l*16 +: 16] = 16'((x > y) ? x : y);
                r[l*16 +: 16]      = 16'((x < y) ? x : y);
            end
            4'd5, 4'd6, 4'd7, 4'd8: begin
                base = (op >= 4'd7) ? 2 : 0;
                sg = (op == 4'd6) || (op == 4'd8);
                for (int l = 0; l < 2; l++) begin
                    x = sg ? longint'($signed(a[(base+l)*8 +: 8])) : longint'(a[(base+l)*8 +: 8]);
                    y = sg ? longint'($signed(b[(base+l)*8 +: 8])) : longint'(b[(base+l)*8 +: 8]);
                    r[32 + l*16 +: 16] = 16'(x);
                    r[l*16 +: 16]      = 16'(y);
                end
            end
            4'd9, 4'd10: for (int g = 0; g < 4; g++) begin
                x = longint'($signed(ab[g*16 +: 16]));
                r[g*8 +: 8] = (op == 4'd9) ? 8'(clamp(x, 0, 255)) : 8'(clamp(x, -128, 127));
            end
            default: return 65'd0;
        endcase
        return {1'b1, r};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5, 4'd6, 4'd7, 4'd8: return "R7";
            4'd9: return "R8";
            4'd10: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the falling edge after the next rising edge
    task automatic run(input logic v, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [64:0] e;
        in_valid = v;
        opcode = op;
        opa = a;
        opb = b;
        e = v ? model(op, a, b) : 65'd0;
        @(posedge clk);
        @(negedge clk);
        check(tag_of(v ? op : 4'd15), {res_valid, res}, e);
    endtask

    logic [15:0] hv [10] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF,
                             16'h7FFE, 16'h8001, 16'h00FF, 16'h0100, 16'hFF80};
    logic [31:0] wv [8]  = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                             32'hFFFFFFFF, 32'h7FFFFFFE, 32'h80000001, 32'h12345678};

    initial begin
        // R10: reset state, during and right after reset
        repeat (3) @(negedge clk);
        check("R10", {res_valid, res}, 65'd0);
        in_valid = 1'b1;
        opcode = 4'd0;
        opa = 32'h5;
        opb = 32'h3;
        @(negedge clk);
        check("R10", {res_valid, res}, 65'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10", {res_valid, res}, 65'd0);

        // R2, R3: word corners and random words
        for (int op = 0; op < 2; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    run(1'b1, 4'(op), wv[i], wv[j]);
                end
            end
            for (int k = 0; k < 1500; k++) begin
                run(1'b1, 4'(op), $urandom, $urandom);
            end
        end

        // R4, R5, R6, R8, R9: all lane corner combinations
        foreach (hv[i0]) foreach (hv[i1]) foreach (hv[j0]) foreach (hv[j1]) begin
            run(1'b1, 4'd2,  {hv[i1], hv[i0]}, {hv[j1], hv[j0]});
            run(1'b1, 4'd3,  {hv[i1], hv[i0]}, {hv[j1], hv[j0]});
            run(1'b1, 4'd4,  {hv[i1], hv[i0]}, {hv[j1], hv[j0]});
            run(1'b1, 4'd9,  {hv[i1], hv[i0]}, {hv[j1], hv[j0]});
            run(1'b1, 4'd10, {hv[i1], hv[i0]}, {hv[j1], hv[j0]});
        end

        // R7: every byte value in every position
        for (int op = 5; op <= 8; op++) begin
            for (int i = 0; i < 256; i++) begin
                run(1'b1, 4'(op), {8'(i), 8'(~i), 8'(i ^ 8'h80), 8'(i + 1)},
                                  {8'(i + 3), 8'(i), 8'(~i), 8'(i ^ 8'h7F)});
            end
        end

        // random mix across all legal codes, back to back
        for (int k = 0; k < 3000; k++) begin
            run(1'b1, 4'($urandom_range(0, 10)), $urandom, $urandom);
        end

        // R1: reserved codes and idle cycles give a zero, invalid result
        for (int op = 11; op < 16; op++) begin
            run(1'b1, 4'(op), 32'hFFFF_FFFF, 32'h8000_0001);
        end
        run(1'b1, 4'd0, 32'h7, 32'h9);
        run(1'b0, 4'd0, 32'h7, 32'h9);
        run(1'b0, 4'd9, 32'h1234_5678, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule